// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This unit is a vector datapath slice that views its two source operands as packed 8-bit elements. The 128-bit operands split into four 32-bit lanes of four bytes each. For every active lane the unit multiplies the four byte pairs that share that lane's position, sums the four products, and adds the total to the matching 32-bit lane of an accumulator vector. The lane result is the new accumulator value for that lane.

A signed/unsigned select chooses how bytes widen before they are multiplied. A width select picks a 64-bit form with two lanes or a 128-bit form with four lanes. In indexed mode, one 32-bit group of the second operand is chosen by a group index and reused by every lane. The result is registered, and a valid strobe marks it one cycle after the request. No condition flags or overflow indication are produced.

A two-state machine tracks the output register. `ST_EMPTY` means the output holds no fresh result. `ST_LOADED` means a result was captured on the previous edge. The transition `EMPTY->LOADED` and the self-loop `LOADED->LOADED` are taken when `in_valid` is high. The transition `LOADED->EMPTY` and the self-loop `EMPTY->EMPTY` are taken when `in_valid` is low. `out_valid` is high exactly in `ST_LOADED`.

Top module: `dotp_unit`

## Requirements
- R1: Lane e (bits 32e+31..32e) of `result` equals lane e of `acc_in` plus the sum over k=0..3 of byte (4e+k) of `src_a` times byte (4e+k) of the selected second-operand group, where byte j occupies bits 8j+7..8j.
- R2: With `is_signed`=1, every byte is sign-extended before multiplying (so 0x80 times 0x80 is +16384).
- R3: With `is_signed`=0, every byte is zero-extended before multiplying (so 0xFF times 0xFF is 65025).
- R4: Lane accumulation wraps modulo 2^32, with no saturation.
- R5: With `wide`=0, only lanes 0 and 1 are computed, and `result[127:64]` is zero.
- R6: With `idx_en`=1, every lane uses second-operand group `idx_sel` (bits 32*idx_sel+31..32*idx_sel of `src_b`) in place of its own group.
- R7: With `idx_en`=1 and `wide`=0, bit 1 of `idx_sel` is ignored, so index 3 gives the same result as index 1, and index 2 the same as index 0.
- R8: `out_valid` equals `in_valid` delayed by exactly one clock cycle.
- R9: When `in_valid` is low, `result` keeps its previous value.
- R10: After reset, `out_valid` is 0 and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; operands are captured on this edge |
| src_a | input | 128 | First packed-byte operand |
| src_b | input | 128 | Second packed-byte operand |
| acc_in | input | 128 | Accumulator vector, four 32-bit lanes |
| is_signed | input | 1 | 1 = signed bytes, 0 = unsigned bytes |
| wide | input | 1 | 1 = 128-bit form (4 lanes), 0 = 64-bit form (2 lanes) |
| idx_en | input | 1 | Indexed mode: broadcast one group of `src_b` to all lanes |
| idx_sel | input | 2 | Group index used in indexed mode |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 128 | Registered accumulated result |

## Verification
The hardest case to reach from the ports is a lane whose accumulation wraps past 2^32. Uniform random operands almost never produce it, because four byte products add at most about 2^18 to the accumulator. The stimulus therefore draws accumulator lanes from values near the wrap points (0xFFFFxxxx and 0x7FFFxxxx) part of the time, and adds directed cases with all-0x80 and all-0xFF operands. A second case that random draws seldom produce is 64-bit indexed mode with index bit 1 set. The bench drives it directly with the same operands under index 3 and index 1, and compares the two results.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
    localparam int ELEM_W   = 8;
    localparam int ELEMS    = 4;
    localparam int LANE_W   = ELEM_W * ELEMS;
    localparam int LANES    = 4;
    localparam int VEC_W    = LANE_W * LANES;
    localparam int IDX_W    = $clog2(LANES);

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } out_state_t;
endpackage

// File: rtl/dotp_lane.sv
// One accumulator lane: four widened byte products summed into a lane value.
module dotp_lane #(
    parameter int EW  = 8,
    parameter int EPL = 4,
    parameter int LW  = 32
) (
    input  logic [EW*EPL-1:0] a_grp,
    input  logic [EW*EPL-1:0] b_grp,
    input  logic [LW-1:0]     acc_lane,
    input  logic              is_signed,
    input  logic              lane_on,
    output logic [LW-1:0]     lane_out
);
    localparam int XW = EW + 1;
    localparam int PW = 2 * XW;

    logic [PW-1:0] prod [EPL];

    generate
        for (genvar k = 0; k < EPL; k++) begin : g_mul
            logic signed [XW-1:0] xa;
            logic signed [XW-1:0] xb;
            logic signed [PW-1:0] p;
            assign xa = $signed({is_signed & a_grp[k*EW+EW-1], a_grp[k*EW +: EW]});
            assign xb = $signed({is_signed & b_grp[k*EW+EW-1], b_grp[k*EW +: EW]});
            assign p  = xa * xb;
            assign prod[k] = p;
        end
    endgenerate

    logic [LW-1:0] total;

    always_comb begin
        total = acc_lane;
        for (int k = 0; k < EPL; k++) begin
            total = total + {{(LW-PW){prod[k][PW-1]}}, prod[k]};
        end
        lane_out = lane_on ? total : '0;
    end
endmodule

// File: rtl/dotp_bcast.sv
// Second-operand routing: each lane's own group, or one group for all lanes.
module dotp_bcast #(
    parameter int LW    = 32,
    parameter int NL    = 4,
    parameter int IW    = 2
) (
    input  logic [LW*NL-1:0]       src_b,
    input  logic                   idx_en,
    input  logic                   wide,
    input  logic [IW-1:0]          idx_sel,
    output logic [NL-1:0][LW-1:0]  b_lanes
);
    logic [IW-1:0] eff_idx;
    logic [LW-1:0] picked;

    always_comb begin
        eff_idx = idx_sel;
        if (!wide) begin
            eff_idx[IW-1] = 1'b0;   // 64-bit form has only two groups
        end
        picked = src_b[eff_idx*LW +: LW];
    end

    generate
        for (genvar e = 0; e < NL; e++) begin : g_route
            assign b_lanes[e] = idx_en ? picked : src_b[e*LW +: LW];
        end
    endgenerate
endmodule

// File: rtl/dotp_unit.sv
module dotp_unit
    import dotp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [VEC_W-1:0]  acc_in,
    input  logic              is_signed,
    input  logic              wide,
    input  logic              idx_en,
    input  logic [IDX_W-1:0]  idx_sel,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result
);
    localparam int HALF_LANES = LANES / 2;

    out_state_t state_q, state_d;

    logic [LANES-1:0][LANE_W-1:0] b_lanes;
    logic [VEC_W-1:0]             next_res;
    logic [VEC_W-1:0]             result_q;

    dotp_bcast #(
        .LW (LANE_W),
        .NL (LANES),
        .IW (IDX_W)
    ) u_bcast (
        .src_b   (src_b),
        .idx_en  (idx_en),
        .wide    (wide),
        .idx_sel (idx_sel),
        .b_lanes (b_lanes)
    );

    generate
        for (genvar e = 0; e < LANES; e++) begin : g_lane
            logic on;
            assign on = (e < HALF_LANES) ? 1'b1 : wide;
            dotp_lane #(
                .EW  (ELEM_W),
                .EPL (ELEMS),
                .LW  (LANE_W)
            ) u_lane (
                .a_grp     (src_a[e*LANE_W +: LANE_W]),
                .b_grp     (b_lanes[e]),
                .acc_lane  (acc_in[e*LANE_W +: LANE_W]),
                .is_signed (is_signed),
                .lane_on   (on),
                .lane_out  (next_res[e*LANE_W +: LANE_W])
            );
        end
    endgenerate

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (in_valid) begin
            result_q <= next_res;
        end
    end

    assign out_valid = (state_q == ST_LOADED);
    assign result    = result_q;
endmodule

// File: rtl/dotp_unit_chk.sv
module dotp_unit_chk
    import dotp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [VEC_W-1:0]  src_a,
    input logic [VEC_W-1:0]  acc_in,
    input logic              wide,
    input logic              out_valid,
    input logic [VEC_W-1:0]  result
);
    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (result[VEC_W-1:VEC_W/2] == '0));

    assert_zero_operand_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide && src_a == '0) |=> (result == $past(acc_in)));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R10: assert (!out_valid && result == '0);
        end
    end
endmodule

bind dotp_unit dotp_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_a     (src_a),
    .acc_in    (acc_in),
    .wide      (wide),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/dotp_unit_tb.sv
module dotp_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] acc_in = '0;
    logic         is_signed = 1'b0;
    logic         wide = 1'b1;
    logic         idx_en = 1'b0;
    logic [1:0]   idx_sel = 2'd0;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dotp_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .src_a     (src_a),
        .src_b     (src_b),
        .acc_in    (acc_in),
        .is_signed (is_signed),
        .wide      (wide),
        .idx_en    (idx_en),
        .idx_sel   (idx_sel),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [127:0] ref_dot(
        input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc,
        input logic sgn, input logic wd, input logic ie, input logic [1:0] ix);
        logic [127:0] r = '0;
        int nl = wd ? 4 : 2;
        int g;
        for (int e = 0; e < nl; e++) begin
            longint s = 0;
            g = ie ? (wd ? int'(ix) : int'(ix[0])) : e;
            for (int k = 0; k < 4; k++) begin
                logic [7:0] ba = a[(4*e+k)*8 +: 8];
                logic [7:0] bb = b[(4*g+k)*8 +: 8];
                longint va = sgn ? longint'($signed(ba)) : longint'(ba);
                longint vb = sgn ? longint'($signed(bb)) : longint'(bb);
                s = s + va * vb;
            end
            r[e*32 +: 32] = acc[e*32 +: 32] + s[31:0];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one request at negedge, check at the following negedge
    task automatic run_op(input string tag,
        input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc,
        input logic sgn, input logic wd, input logic ie, input logic [1:0] ix,
        output logic [127:0] got);
        @(negedge clk);
        src_a = a; src_b = b; acc_in = acc; is_signed = sgn;
        wide = wd; idx_en = ie; idx_sel = ix; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        got = result;
        check({tag, " R8 valid"}, {127'd0, out_valid}, 128'd1);
        check(tag, result, ref_dot(a, b, acc, sgn, wd, ie, ix));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [127:0] r1, r3, held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset valid", {127'd0, out_valid}, 128'd0);
        check("R10 reset result", result, 128'd0);
        rst_n = 1'b1;

        // R2 signed extreme: 0x80*0x80 per byte
        run_op("R2 signed 0x80", {16{8'h80}}, {16{8'h80}}, '0, 1'b1, 1'b1, 1'b0, 2'd0, r1);
        check("R2 lane value", {96'd0, r1[31:0]}, 128'd65536);
        // R3 unsigned extreme: 0xFF*0xFF per byte
        run_op("R3 unsigned 0xFF", {16{8'hFF}}, {16{8'hFF}}, '0, 1'b0, 1'b1, 1'b0, 2'd0, r1);
        check("R3 lane value", {96'd0, r1[31:0]}, 128'd260100);
        // R2 signed 0xFF*0x01 is -1 each, -4 per lane
        run_op("R2 signed neg", {16{8'hFF}}, {16{8'h01}}, '0, 1'b1, 1'b1, 1'b0, 2'd0, r1);
        check("R2 lane neg", {96'd0, r1[31:0]}, {96'd0, 32'hFFFF_FFFC});
        // R4 wrap upward and downward
        run_op("R4 wrap up", {16{8'h01}}, {16{8'h01}}, {4{32'hFFFF_FFFE}}, 1'b0, 1'b1, 1'b0, 2'd0, r1);
        check("R4 lane wrap", {96'd0, r1[31:0]}, 128'd2);
        run_op("R4 wrap down", {16{8'hFF}}, {16{8'h01}}, '0, 1'b1, 1'b1, 1'b0, 2'd0, r1);
        // R1 distinct lane bytes
        run_op("R1 lane bytes", 128'h0403_0201_0807_0605_0C0B_0A09_100F_0E0D,
               128'h0101_0101_0202_0202_0303_0303_0404_0404, 128'h10_0000_0020_0000_0030_0000_0040,
               1'b0, 1'b1, 1'b0, 2'd0, r1);
        // R5 narrow mode clears upper half
        run_op("R5 narrow", rnd128(), rnd128(), {128{1'b1}}, 1'b1, 1'b0, 1'b0, 2'd0, r1);
        check("R5 upper zero", {64'd0, r1[127:64]}, 128'd0);
        // R6 each index in wide indexed mode
        for (int i = 0; i < 4; i++) begin
            run_op("R6 indexed", rnd128(), rnd128(), rnd128(), 1'b1, 1'b1, 1'b1, 2'(i), r1);
        end
        // R7 index bit 1 ignored in narrow mode
        src_b = rnd128();
        src_a = rnd128();
        acc_in = rnd128();
        begin
            logic [127:0] a = src_a, b = src_b, c = acc_in;
            run_op("R7 idx3", a, b, c, 1'b0, 1'b0, 1'b1, 2'd3, r3);
            run_op("R7 idx1", a, b, c, 1'b0, 1'b0, 1'b1, 2'd1, r1);
            check("R7 idx3 equals idx1", r3, r1);
            run_op("R7 idx2", a, b, c, 1'b1, 1'b0, 1'b1, 2'd2, r3);
            run_op("R7 idx0", a, b, c, 1'b1, 1'b0, 1'b1, 2'd0, r1);
            check("R7 idx2 equals idx0", r3, r1);
        end
        // R9 idle hold and R8 valid drop
        held = result;
        src_a = rnd128(); src_b = rnd128(); acc_in = rnd128();
        repeat (3) @(negedge clk);
        check("R8 valid low", {127'd0, out_valid}, 128'd0);
        check("R9 hold", result, held);

        // constrained random, with accumulators near wrap points
        for (int n = 0; n < 300; n++) begin
            logic [127:0] acc = rnd128();
            if ($urandom_range(0, 2) == 0) begin
                for (int e = 0; e < 4; e++) begin
                    acc[e*32+16 +: 16] = ($urandom_range(0, 1) != 0) ? 16'hFFFF : 16'h7FFF;
                end
            end
            run_op("R1 random", rnd128(), rnd128(), acc, 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), r1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule